// File: doc/BRIEF.md
# Hot-plug slot event latch and interrupt aggregator

This block keeps one 32-bit status and control word per hot-plug slot plus one controller-level word. Raw slot signals (a two-bit presence code, the retention latch sensor, the attention button and two power-fault lines) are brought into the clock domain through a two-flop synchronizer. Each change of interest is then caught in a sticky event bit, which software clears by writing one to it.

Every event bit has its own interrupt mask, and two of them also have an error mask. Unmasked events are summarised into a locator word. Bit 0 of that word stands for a finished controller command, and bit n+1 stands for slot n. The locator drives a level interrupt line gated by a global mask. A separate error line collects latch-change and connected-power-fault events, as well as arbiter errors, behind their own masks.

The command engine lives elsewhere. It supplies only a one-cycle completion pulse, an arbiter error pulse and the current indicator and slot-state codes that are shown in each slot word. Register access is a simple word port: address 0 is the controller word, address n+1 is slot n, and reads are combinational.

Top module: `slot_evt_agg`

## Requirements
- R1: After reset every event bit and both controller event bits are 0. Every slot interrupt mask (bits 28:24) and error mask (bits 30:29) is 1. The controller word reads 0x0000000F. irq, serr and the locator are 0.
- R2: A change of either presence bit (raw input to slot word bits 11:10) sets bit 16, and any change of the latch sensor sets bit 19. The event bit becomes visible after the third rising clock edge following the raw change, and not after the second.
- R3: A 0-to-1 transition of the attention button sets bit 18. A 1-to-0 transition sets nothing.
- R4: Assertion of the isolated power fault sets bit 17, and assertion of the connected power fault sets bit 20. Deassertion of either sets nothing.
- R5: Writing a slot word clears exactly the event bits (20:16) written as 1 and leaves the others set. Masks take the written bits 28:24 and 30:29.
- R6: When an event and a clearing write to the same bit fall in the same cycle, the bit stays set. This holds for slot events and for the controller command bit.
- R7: Slot word status fields: bits 5:0 show the indicator/slot-state input, bit 6 reads 0 while either power fault is present, bit 7 shows the button and bit 8 the latch sensor. Bit 9 shows 66 MHz capability, bits 11:10 the presence code (3 = empty), and bits 14:12 the PCI-X capability with bit 14 forced to 0 on programming revision 1. Bits 15, 23:21 and 31 read 0, as does any address above the last slot.
- R8: Locator bit n+1 is 1 exactly when slot n has a latched event whose interrupt mask is 0. Locator bit 0 is 1 exactly when the command bit is set and controller mask bit 2 is 0.
- R9: irq is 1 exactly when any locator bit is 1 and controller mask bit 0 is 0.
- R10: serr is 1 exactly when controller bit 1 is 0 and at least one of these holds: the arbiter bit is set with controller bit 3 clear; a slot's latch-change bit is set with its bit 29 clear; or a slot's connected-fault bit is set with its bit 30 clear.
- R11: In the controller word, a completion pulse sets bit 16 and an arbiter pulse sets bit 17 on the next edge. Both bits are cleared by writing 1, bits 3:0 are writable masks, and bits 31:18 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prsnt_raw | input | 2*NUM_SLOTS | Raw presence code per slot |
| mrl_raw | input | NUM_SLOTS | Raw latch sensor per slot |
| btn_raw | input | NUM_SLOTS | Raw attention button per slot |
| iflt_raw | input | NUM_SLOTS | Raw isolated power fault, 1 = fault |
| cflt_raw | input | NUM_SLOTS | Raw connected power fault, 1 = fault |
| ind_state | input | 6*NUM_SLOTS | Slot state and indicator codes from the command engine |
| m66_cap | input | NUM_SLOTS | 66 MHz capability per slot |
| pcix_cap | input | 3*NUM_SLOTS | PCI-X capability code per slot |
| cmd_done | input | 1 | Command completion pulse |
| arb_err | input | 1 | Arbiter error pulse |
| reg_addr | input | AW | Word select: 0 controller, n+1 slot n |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Interrupt request |
| serr | output | 1 | System error request |
| locator | output | NUM_SLOTS+1 | Pending-source vector |

## Verification
The clash that matters is an event arriving in the very cycle in which software writes one to clear the same sticky bit. The bench sets a presence-change bit, then toggles the presence input again. It counts two clock edges and raises the clearing write so that it meets the synchronized event at the third edge. The bit must still read 1 afterwards, and a later lone clear must bring it to 0. The same collision is staged on the controller word by raising the completion pulse together with a clearing write.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
  localparam int unsigned NUM_EV = 5;
  // event index inside a slot; bit positions 16+i and 24+i follow this order
  localparam int unsigned EV_PRS  = 0;
  localparam int unsigned EV_IFLT = 1;
  localparam int unsigned EV_BTN  = 2;
  localparam int unsigned EV_MRL  = 3;
  localparam int unsigned EV_CFLT = 4;
  localparam int unsigned RAW_W   = 6;

  typedef struct packed {
    logic [1:0] prs;
    logic       mrl;
    logic       btn;
    logic       iflt;
    logic       cflt;
  } slot_raw_t;
endpackage

// File: rtl/slot_sync.sv
module slot_sync
  import hpslot_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_raw_t         raw_i,
  output slot_raw_t         stat_o,
  output logic [NUM_EV-1:0] evt_o
);
  logic [STAGES-1:0][RAW_W-1:0] pipe_q, pipe_d;
  logic [RAW_W-1:0]             prev_q;
  slot_raw_t                    cur, prv;

  always_comb begin
    pipe_d[0] = raw_i;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign cur    = slot_raw_t'(pipe_q[STAGES-1]);
  assign prv    = slot_raw_t'(prev_q);
  assign stat_o = cur;

  always_comb begin
    evt_o          = '0;
    evt_o[EV_PRS]  = (cur.prs != prv.prs);
    evt_o[EV_IFLT] = cur.iflt & ~prv.iflt;
    evt_o[EV_BTN]  = cur.btn & ~prv.btn;
    evt_o[EV_MRL]  = cur.mrl ^ prv.mrl;
    evt_o[EV_CFLT] = cur.cflt & ~prv.cflt;
  end
endmodule

// File: rtl/slot_reg.sv
module slot_reg
  import hpslot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NUM_EV-1:0] w_clr,
  input  logic [NUM_EV-1:0] w_imsk,
  input  logic [1:0]        w_smsk,
  input  logic [NUM_EV-1:0] evt,
  output logic [NUM_EV-1:0] lat_o,
  output logic [NUM_EV-1:0] imsk_o,
  output logic [1:0]        smsk_o,
  output logic              pend_o,
  output logic              err_o
);
  logic [NUM_EV-1:0] lat_q, lat_d, imsk_q, imsk_d;
  logic [1:0]        smsk_q, smsk_d;
  logic              upd;

  assign upd = we | (|evt);

  always_comb begin
    lat_d  = (lat_q & ~(we ? w_clr : '0)) | evt;
    imsk_d = we ? w_imsk : imsk_q;
    smsk_d = we ? w_smsk : smsk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      imsk_q <= '1;
      smsk_q <= '1;
    end else if (upd) begin
      lat_q  <= lat_d;
      imsk_q <= imsk_d;
      smsk_q <= smsk_d;
    end
  end

  assign lat_o  = lat_q;
  assign imsk_o = imsk_q;
  assign smsk_o = smsk_q;
  assign pend_o = |(lat_q & ~imsk_q);
  assign err_o  = (lat_q[EV_MRL] & ~smsk_q[0]) | (lat_q[EV_CFLT] & ~smsk_q[1]);
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [3:0]           w_msk,
  input  logic [1:0]           w_clr,
  input  logic                 cmd_done,
  input  logic                 arb_err,
  input  logic [NUM_SLOTS-1:0] slot_pend,
  input  logic [NUM_SLOTS-1:0] slot_err,
  output logic [31:0]          word_o,
  output logic [NUM_SLOTS:0]   loc_o,
  output logic                 irq_o,
  output logic                 serr_o
);
  logic [3:0] msk_q, msk_d;
  logic       cmd_q, cmd_d, arb_q, arb_d, upd;

  assign upd = we | cmd_done | arb_err;

  always_comb begin
    msk_d = we ? w_msk : msk_q;
    cmd_d = cmd_done | (cmd_q & ~(we & w_clr[0]));
    arb_d = arb_err  | (arb_q & ~(we & w_clr[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= 4'hF;
      cmd_q <= 1'b0;
      arb_q <= 1'b0;
    end else if (upd) begin
      msk_q <= msk_d;
      cmd_q <= cmd_d;
      arb_q <= arb_d;
    end
  end

  assign word_o = {14'b0, arb_q, cmd_q, 12'b0, msk_q};
  assign loc_o  = {slot_pend, cmd_q & ~msk_q[2]};
  assign irq_o  = (|loc_o) & ~msk_q[0];
  assign serr_o = ~msk_q[1] & ((arb_q & ~msk_q[3]) | (|slot_err));
endmodule

// File: rtl/slot_evt_agg.sv
module slot_evt_agg
  import hpslot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned PI_REV    = 2,
  parameter int unsigned SYNC_STG  = 2,
  localparam int unsigned AW       = $clog2(NUM_SLOTS + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_SLOTS-1:0] prsnt_raw,
  input  logic [NUM_SLOTS-1:0]   mrl_raw,
  input  logic [NUM_SLOTS-1:0]   btn_raw,
  input  logic [NUM_SLOTS-1:0]   iflt_raw,
  input  logic [NUM_SLOTS-1:0]   cflt_raw,
  input  logic [6*NUM_SLOTS-1:0] ind_state,
  input  logic [NUM_SLOTS-1:0]   m66_cap,
  input  logic [3*NUM_SLOTS-1:0] pcix_cap,
  input  logic                   cmd_done,
  input  logic                   arb_err,
  input  logic [AW-1:0]          reg_addr,
  input  logic                   reg_we,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   irq,
  output logic                   serr,
  output logic [NUM_SLOTS:0]     locator
);
  localparam logic [2:0] PCIX_KEEP = (PI_REV == 1) ? 3'b011 : 3'b111;

  logic [1:0]                  rsync_q;
  logic                        rst_q_n;
  logic [NUM_SLOTS*NUM_EV-1:0] evt_all, lat_all;
  logic [NUM_SLOTS-1:0]        pend, err;
  logic [31:0]                 slot_word [NUM_SLOTS];
  logic [31:0]                 ctl_word;
  logic                        ctl_we;
  logic                        unused_wbits;

  assign unused_wbits = ^{reg_wdata[31], reg_wdata[23:21], reg_wdata[15:4]};

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  assign ctl_we = reg_we && (reg_addr == '0);

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    slot_raw_t         raw, stat;
    logic [NUM_EV-1:0] evt, lat, imsk;
    logic [1:0]        smsk;
    logic              s_we;

    assign raw  = '{prs: prsnt_raw[2*n +: 2], mrl: mrl_raw[n], btn: btn_raw[n],
                    iflt: iflt_raw[n], cflt: cflt_raw[n]};
    assign s_we = reg_we && (reg_addr == AW'(n + 1));

    slot_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_q_n), .raw_i(raw), .stat_o(stat), .evt_o(evt)
    );

    slot_reg u_reg (
      .clk(clk), .rst_n(rst_q_n), .we(s_we),
      .w_clr(reg_wdata[20:16]), .w_imsk(reg_wdata[28:24]), .w_smsk(reg_wdata[30:29]),
      .evt(evt), .lat_o(lat), .imsk_o(imsk), .smsk_o(smsk),
      .pend_o(pend[n]), .err_o(err[n])
    );

    assign evt_all[n*NUM_EV +: NUM_EV] = evt;
    assign lat_all[n*NUM_EV +: NUM_EV] = lat;
    assign slot_word[n] = {1'b0, smsk, imsk, 3'b000, lat, 1'b0,
                           pcix_cap[3*n +: 3] & PCIX_KEEP, stat.prs, m66_cap[n],
                           stat.mrl, stat.btn, ~(stat.iflt | stat.cflt),
                           ind_state[6*n +: 6]};
  end

  ctl_reg #(.NUM_SLOTS(NUM_SLOTS)) u_ctl (
    .clk(clk), .rst_n(rst_q_n), .we(ctl_we),
    .w_msk(reg_wdata[3:0]), .w_clr(reg_wdata[17:16]),
    .cmd_done(cmd_done), .arb_err(arb_err),
    .slot_pend(pend), .slot_err(err),
    .word_o(ctl_word), .loc_o(locator), .irq_o(irq), .serr_o(serr)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctl_word;
    for (int n = 0; n < NUM_SLOTS; n++)
      if (reg_addr == AW'(n + 1)) reg_rdata = slot_word[n];
  end
endmodule

// File: rtl/slot_evt_agg_chk.sv
module slot_evt_agg_chk #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NE        = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_done,
  input logic                   cmd_lat,
  input logic                   gmsk_serr,
  input logic [NUM_SLOTS*NE-1:0] evt,
  input logic [NUM_SLOTS*NE-1:0] lat,
  input logic [NUM_SLOTS:0]     locator,
  input logic                   irq,
  input logic                   serr
);
  // R11
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> cmd_lat);

  // R6
  evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((lat & $past(evt)) == $past(evt)));

  // R8
  loc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|locator[NUM_SLOTS:1]) |-> (|lat));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|locator));

  // R10
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> !gmsk_serr);
endmodule

bind slot_evt_agg slot_evt_agg_chk #(.NUM_SLOTS(NUM_SLOTS), .NE(5)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .cmd_done(cmd_done), .cmd_lat(ctl_word[16]),
  .gmsk_serr(ctl_word[1]), .evt(evt_all), .lat(lat_all),
  .locator(locator), .irq(irq), .serr(serr)
);

// File: tb/sim_slot_evt_agg.sv
module sim_slot_evt_agg;
  localparam int N  = 4;
  localparam int AW = $clog2(N + 2);

  logic clk = 1'b0;
  logic rst_n;
  logic [2*N-1:0] prsnt_raw;
  logic [N-1:0]   mrl_raw, btn_raw, iflt_raw, cflt_raw, m66_cap;
  logic [6*N-1:0] ind_state;
  logic [3*N-1:0] pcix_cap;
  logic cmd_done, arb_err, reg_we;
  logic [AW-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq, serr;
  logic [N:0] locator;

  // bench-side input values and expected state
  logic [1:0] prs_v [N];
  logic       mrl_v [N], btn_v [N], iflt_v [N], cflt_v [N];
  logic [4:0] m_lat [N], m_imsk [N];
  logic [1:0] m_smsk [N];
  logic [3:0] m_cmsk;
  logic       m_cmd, m_arb;
  int vecs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int n = 0; n < N; n++) begin
      prsnt_raw[2*n +: 2] = prs_v[n];
      mrl_raw[n]  = mrl_v[n];
      btn_raw[n]  = btn_v[n];
      iflt_raw[n] = iflt_v[n];
      cflt_raw[n] = cflt_v[n];
      ind_state[6*n +: 6] = 6'(6'h39 ^ n);
      m66_cap[n]  = n[0];
      pcix_cap[3*n +: 3] = 3'(n + 3);
    end
  end

  slot_evt_agg #(.NUM_SLOTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .prsnt_raw(prsnt_raw), .mrl_raw(mrl_raw),
    .btn_raw(btn_raw), .iflt_raw(iflt_raw), .cflt_raw(cflt_raw),
    .ind_state(ind_state), .m66_cap(m66_cap), .pcix_cap(pcix_cap),
    .cmd_done(cmd_done), .arb_err(arb_err), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .serr(serr), .locator(locator)
  );

  function automatic logic [31:0] exp_slot(int n);
    return {1'b0, m_smsk[n], m_imsk[n], 3'b000, m_lat[n], 1'b0, 3'(n + 3),
            prs_v[n], 1'(n[0]), mrl_v[n], btn_v[n], ~(iflt_v[n] | cflt_v[n]),
            6'(6'h39 ^ n)};
  endfunction

  function automatic logic [N:0] exp_loc();
    logic [N:0] l;
    l[0] = m_cmd & ~m_cmsk[2];
    for (int n = 0; n < N; n++) l[n+1] = |(m_lat[n] & ~m_imsk[n]);
    return l;
  endfunction

  function automatic logic exp_serr();
    logic s;
    s = m_arb & ~m_cmsk[3];
    for (int n = 0; n < N; n++)
      s = s | (m_lat[n][3] & ~m_smsk[n][0]) | (m_lat[n][4] & ~m_smsk[n][1]);
    return s & ~m_cmsk[1];
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, string tag, logic [31:0] exp);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    cmp(tag, reg_rdata, exp);
  endtask

  task automatic check_all(string tag);
    rd(0, {tag, " R11 ctl word"}, {14'b0, m_arb, m_cmd, 12'b0, m_cmsk});
    for (int n = 0; n < N; n++) rd(n + 1, {tag, " R7 slot word"}, exp_slot(n));
    rd(N + 1, {tag, " R7 unmapped"}, 32'h0);
    cmp({tag, " R8 locator"}, 32'(locator), 32'(exp_loc()));
    cmp({tag, " R9 irq"}, 32'(irq), 32'((|exp_loc()) & ~m_cmsk[0]));
    cmp({tag, " R10 serr"}, 32'(serr), 32'(exp_serr()));
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] slot_wd(int n, logic [4:0] clr);
    return {1'b0, m_smsk[n], m_imsk[n], 3'b000, clr, 16'h0000};
  endfunction

  // drive one raw field, confirm no effect after two edges, then after three
  task automatic stim(int n, int e, logic [1:0] v, string tag);
    logic fire;
    @(negedge clk);
    case (e)
      0: begin fire = (prs_v[n] != v); prs_v[n] = v; end
      1: begin fire = v[0] & ~iflt_v[n]; iflt_v[n] = v[0]; end
      2: begin fire = v[0] & ~btn_v[n]; btn_v[n] = v[0]; end
      3: begin fire = (mrl_v[n] != v[0]); mrl_v[n] = v[0]; end
      default: begin fire = v[0] & ~cflt_v[n]; cflt_v[n] = v[0]; end
    endcase
    @(posedge clk); @(posedge clk);
    rd(n + 1, {tag, " R2 not before third edge"}, exp_slot(n));
    @(posedge clk);
    if (fire) m_lat[n][e] = 1'b1;
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_done = 0; arb_err = 0; reg_we = 0;
    reg_addr = '0; reg_wdata = '0;
    for (int n = 0; n < N; n++) begin
      prs_v[n] = 2'b00; mrl_v[n] = 0; btn_v[n] = 0; iflt_v[n] = 0; cflt_v[n] = 0;
      m_lat[n] = 5'h00; m_imsk[n] = 5'h1F; m_smsk[n] = 2'b11;
    end
    m_cmsk = 4'hF; m_cmd = 0; m_arb = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check_all("R1 reset");

    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin m_cmsk = 4'h0; end
        1: begin m_cmsk = 4'h5; end
        2: begin m_cmsk = 4'hA; end
        default: begin m_cmsk = 4'h0; end
      endcase
      wr(0, {28'h0, m_cmsk});
      for (int n = 0; n < N; n++) begin
        m_imsk[n] = (k == 0) ? 5'h00 : (k == 1) ? 5'h15 : (k == 2) ? 5'h0A : 5'h1F;
        m_smsk[n] = 2'(k);
        wr(n + 1, slot_wd(n, 5'h00));
      end
      check_all("R5 mask write");

      // controller pulses
      @(negedge clk); cmd_done = 1; arb_err = 1;
      @(negedge clk); cmd_done = 0; arb_err = 0;
      m_cmd = 1; m_arb = 1;
      check_all("R11 pulses");
      wr(0, {14'h0, 2'b11, 12'h0, m_cmsk});
      m_cmd = 0; m_arb = 0;
      check_all("R11 clear");

      for (int n = 0; n < N; n++) begin
        for (int e = 0; e < 5; e++) begin
          stim(n, e, (e == 0) ? 2'b11 : 2'b01, "R2 R3 R4 assert");
          wr(n + 1, slot_wd(n, 5'h00));
          check_all("R5 zero clear keeps");
          wr(n + 1, slot_wd(n, 5'(1 << e)));
          m_lat[n][e] = 1'b0;
          check_all("R5 one clears");
          stim(n, e, 2'b00, "R2 R3 R4 release");
          wr(n + 1, slot_wd(n, 5'h1F));
          m_lat[n] = 5'h00;
          check_all("R5 clear all");
        end
      end
    end

    // R6: presence event meets a clearing write on the same edge
    stim(1, 0, 2'b10, "R6 setup");
    @(negedge clk); prs_v[1] = 2'b01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_addr = AW'(2); reg_wdata = slot_wd(1, 5'h01); reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    check_all("R6 event wins slot");
    wr(2, slot_wd(1, 5'h01));
    m_lat[1] = 5'h00;
    check_all("R6 later clear");

    // R6: completion pulse meets a clearing write
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0; m_cmd = 1;
    @(negedge clk);
    cmd_done = 1; reg_addr = '0; reg_wdata = {15'h0, 1'b1, 12'h0, m_cmsk}; reg_we = 1;
    @(negedge clk); cmd_done = 0; reg_we = 0;
    check_all("R6 event wins ctl");
    wr(0, {15'h0, 1'b1, 12'h0, m_cmsk});
    m_cmd = 0;
    check_all("R6 ctl clear");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule